// File: doc/BRIEF.md
# Dual-Type Pin Bank Controller

This block drives the digital controls of a bank of chip pins of two kinds. Standard pins are three-state. Each has a data bit and a direction bit, and each has a programmable pull-up. High-voltage pins can only drive high or be released. The same pin can also be sampled as an input once its driver is released. For every pin the block produces a PMOS enable, an NMOS enable and, on standard pins, a pull-up enable. One global bit gates all the pull-ups.

Software reaches the registers over a small port-addressed bus that models dedicated I/O instructions. This bus does not map into data memory. The select field names a register kind and a port index. A read of a data select returns the pad levels after a synchronizer, not the latched data bits, so a high-voltage pin released to 0 reads as whatever the outside world drives. Pad voltages and resistor options are outside the block; only the enables are produced.

Top module: `gpio_pin_ctrl`

## Requirements
- R1: After reset every data bit, direction bit and the global pull-up bit is 0. All PMOS, NMOS and pull-up enables are then 0.
- R2: A standard pin with direction bit 1 is an output. Its PMOS enable equals its data bit and its NMOS enable equals the inverted data bit. Both enables are never on together.
- R3: A standard pin with direction bit 0 has both its PMOS and its NMOS enable at 0.
- R4: A standard pin's pull-up enable is 1 exactly when the global pull-up bit is 1 and that pin's data bit is 1. The direction bit does not affect it.
- R5: While the global pull-up bit is 0, every pull-up enable is 0.
- R6: A high-voltage pin's PMOS enable equals its data bit. Its NMOS enable is always 0, so a data bit of 0 leaves the pin undriven.
- R7: A read of a standard-data or high-voltage-data select returns the pad levels of that port through a synchronizer of SYNC_STAGES flops (default 2). A pad change made before clock edge k is visible after edge k+1 and is not visible after edge k alone.
- R8: A write takes effect at the next rising clock edge. It changes only the register addressed by the select. A write to a port index beyond the implemented ports changes nothing. With no write, no enable changes.
- R9: The select is {kind[1:0], index[IDX_W-1:0]}. Kind 0 is standard data, 1 is standard direction, 2 is high-voltage data and 3 is the miscellaneous register. In the miscellaneous register the global pull-up bit is data bit 0. Reading the direction kind returns the direction register. Reading kind 3 returns the pull-up bit in bit 0 and zeros above it. Reading an unimplemented index returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| sel | input | IDX_W+2 | Register select {kind, index} |
| wr_data | input | PORT_W | Write data |
| rd_data | output | PORT_W | Read data for the current select (combinational) |
| std_pad_in | input | STD_PORTS*PORT_W | Standard pad levels |
| hv_pad_in | input | HV_PORTS*PORT_W | High-voltage pad levels |
| std_pmos_en | output | STD_PORTS*PORT_W | Standard pin PMOS enables |
| std_nmos_en | output | STD_PORTS*PORT_W | Standard pin NMOS enables |
| std_pu_en | output | STD_PORTS*PORT_W | Standard pin pull-up enables |
| hv_pmos_en | output | HV_PORTS*PORT_W | High-voltage pin PMOS enables |
| hv_nmos_en | output | HV_PORTS*PORT_W | High-voltage pin NMOS enables |

## Verification
The hardest case to reach is a pull-up that stays on for an input pin. It needs the global bit set, the data bit set and the direction bit cleared, in any order. It also needs writes to other kinds and to invalid indices in between that must leave it alone. Random writes over the full select space, including unimplemented indices, produce all orderings of these three bits. The outputs are compared against a bench model after every write. Directed steps then change a pad and read it after one edge and after two, to pin down the synchronizer latency.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   typedef enum logic [1:0] {
      SEL_STD_DATA = 2'd0,
      SEL_STD_DIR  = 2'd1,
      SEL_HV_DATA  = 2'd2,
      SEL_MISC     = 2'd3
   } sel_kind_e;

   localparam int MISC_PU_BIT = 0;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_std_port.sv
module gpio_std_port #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         data_we,
   input  logic         dir_we,
   input  logic [W-1:0] wr_val,
   input  logic         pu_global,
   output logic [W-1:0] data_q,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] pmos_en,
   output logic [W-1:0] nmos_en,
   output logic [W-1:0] pu_en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         dir_q  <= '0;
      end else begin
         if (data_we) data_q <= wr_val;
         if (dir_we)  dir_q  <= wr_val;
      end
   end

   always_comb begin
      pmos_en = dir_q & data_q;
      nmos_en = dir_q & ~data_q;
      pu_en   = pu_global ? data_q : '0;
   end
endmodule

// File: rtl/gpio_hv_port.sv
module gpio_hv_port #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         data_we,
   input  logic [W-1:0] wr_val,
   output logic [W-1:0] data_q,
   output logic [W-1:0] pmos_en,
   output logic [W-1:0] nmos_en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_q <= '0;
      else if (data_we) data_q <= wr_val;
   end

   assign pmos_en = data_q;
   assign nmos_en = '0;
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
   import gpio_pkg::*;
#(
   parameter int PORT_W      = 4,
   parameter int STD_PORTS   = 3,
   parameter int HV_PORTS    = 4,
   parameter int IDX_W       = 2,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = IDX_W + 2,
   localparam int STD_PINS   = STD_PORTS * PORT_W,
   localparam int HV_PINS    = HV_PORTS * PORT_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [SEL_W-1:0]    sel,
   input  logic [PORT_W-1:0]   wr_data,
   output logic [PORT_W-1:0]   rd_data,
   input  logic [STD_PINS-1:0] std_pad_in,
   input  logic [HV_PINS-1:0]  hv_pad_in,
   output logic [STD_PINS-1:0] std_pmos_en,
   output logic [STD_PINS-1:0] std_nmos_en,
   output logic [STD_PINS-1:0] std_pu_en,
   output logic [HV_PINS-1:0]  hv_pmos_en,
   output logic [HV_PINS-1:0]  hv_nmos_en
);
   generate
      if (PORT_W < 1 || PORT_W <= MISC_PU_BIT) begin : g_bad_width
         $error("PORT_W too small");
      end
      if (STD_PORTS < 1 || HV_PORTS < 1) begin : g_bad_count
         $error("need at least one port of each kind");
      end
      if ((2 ** IDX_W) < STD_PORTS || (2 ** IDX_W) < HV_PORTS) begin : g_bad_idx
         $error("IDX_W cannot address every port");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   sel_kind_e        kind;
   logic [IDX_W-1:0] idx;
   logic             pu_global_q;

   assign kind = sel_kind_e'(sel[SEL_W-1 -: 2]);
   assign idx  = sel[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          pu_global_q <= 1'b0;
      else if (wr_en && kind == SEL_MISC)  pu_global_q <= wr_data[MISC_PU_BIT];
   end

   logic [PORT_W-1:0] std_dir   [STD_PORTS];
   logic [PORT_W-1:0] std_data  [STD_PORTS];
   logic [PORT_W-1:0] hv_data   [HV_PORTS];
   logic [STD_PINS-1:0] std_pad_s;
   logic [HV_PINS-1:0]  hv_pad_s;

   genvar p;
   generate
      for (p = 0; p < STD_PORTS; p++) begin : g_std
         logic hit;
         assign hit = wr_en && (idx == IDX_W'(p));
         gpio_std_port #(.W(PORT_W)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .data_we   (hit && kind == SEL_STD_DATA),
            .dir_we    (hit && kind == SEL_STD_DIR),
            .wr_val    (wr_data),
            .pu_global (pu_global_q),
            .data_q    (std_data[p]),
            .dir_q     (std_dir[p]),
            .pmos_en   (std_pmos_en[p*PORT_W +: PORT_W]),
            .nmos_en   (std_nmos_en[p*PORT_W +: PORT_W]),
            .pu_en     (std_pu_en[p*PORT_W +: PORT_W])
         );
      end
      for (p = 0; p < HV_PORTS; p++) begin : g_hv
         gpio_hv_port #(.W(PORT_W)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .data_we (wr_en && kind == SEL_HV_DATA && idx == IDX_W'(p)),
            .wr_val  (wr_data),
            .data_q  (hv_data[p]),
            .pmos_en (hv_pmos_en[p*PORT_W +: PORT_W]),
            .nmos_en (hv_nmos_en[p*PORT_W +: PORT_W])
         );
      end
   endgenerate

   gpio_sync #(.W(STD_PINS), .STAGES(SYNC_STAGES)) u_std_sync (
      .clk (clk), .rst_n (rst_n), .d (std_pad_in), .q (std_pad_s)
   );
   gpio_sync #(.W(HV_PINS), .STAGES(SYNC_STAGES)) u_hv_sync (
      .clk (clk), .rst_n (rst_n), .d (hv_pad_in), .q (hv_pad_s)
   );

   always_comb begin
      rd_data = '0;
      case (kind)
         SEL_STD_DATA: begin
            for (int i = 0; i < STD_PORTS; i++)
               if (idx == IDX_W'(i)) rd_data = std_pad_s[i*PORT_W +: PORT_W];
         end
         SEL_STD_DIR: begin
            for (int i = 0; i < STD_PORTS; i++)
               if (idx == IDX_W'(i)) rd_data = std_dir[i];
         end
         SEL_HV_DATA: begin
            for (int i = 0; i < HV_PORTS; i++)
               if (idx == IDX_W'(i)) rd_data = hv_pad_s[i*PORT_W +: PORT_W];
         end
         default: rd_data[MISC_PU_BIT] = pu_global_q;
      endcase
   end

   logic unused_ok;
   always_comb begin
      unused_ok = 1'b0;
      for (int i = 0; i < STD_PORTS; i++) unused_ok = unused_ok ^ (^std_data[i]);
      for (int i = 0; i < HV_PORTS; i++)  unused_ok = unused_ok ^ (^hv_data[i]);
   end
endmodule

// File: rtl/gpio_pin_ctrl_chk.sv
module gpio_pin_ctrl_chk #(
   parameter int PORT_W    = 4,
   parameter int STD_PORTS = 3,
   parameter int HV_PORTS  = 4,
   parameter int IDX_W     = 2
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          wr_en,
   input logic [IDX_W+1:0]              sel,
   input logic [PORT_W-1:0]             wr_data,
   input logic [STD_PORTS*PORT_W-1:0]   std_pmos_en,
   input logic [STD_PORTS*PORT_W-1:0]   std_nmos_en,
   input logic [STD_PORTS*PORT_W-1:0]   std_pu_en,
   input logic [HV_PORTS*PORT_W-1:0]    hv_pmos_en
);
   assert_no_shoot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (std_pmos_en & std_nmos_en) == '0);

   assert_pu_not_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (std_pu_en & std_nmos_en) == '0);

   assert_pu_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel[IDX_W+1 -: 2] == 2'd3 && !wr_data[0]) |=> std_pu_en == '0);

   assert_input_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == {2'd1, IDX_W'(0)} && wr_data == '0)
      |=> (std_pmos_en[PORT_W-1:0] == '0 && std_nmos_en[PORT_W-1:0] == '0));

   assert_hv_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == {2'd2, IDX_W'(0)})
      |=> hv_pmos_en[PORT_W-1:0] == $past(wr_data));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(std_pmos_en) && $stable(std_nmos_en)
                  && $stable(std_pu_en) && $stable(hv_pmos_en)));
endmodule

bind gpio_pin_ctrl gpio_pin_ctrl_chk #(
   .PORT_W(PORT_W), .STD_PORTS(STD_PORTS), .HV_PORTS(HV_PORTS), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wr_data(wr_data),
   .std_pmos_en(std_pmos_en), .std_nmos_en(std_nmos_en),
   .std_pu_en(std_pu_en), .hv_pmos_en(hv_pmos_en)
);

// File: tb/sim_gpio_pin_ctrl.sv
module sim_gpio_pin_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int PORT_W     = 4;
   localparam int STD_PORTS  = 3;
   localparam int HV_PORTS   = 4;
   localparam int IDX_W      = 2;
   localparam int SEL_W      = IDX_W + 2;
   localparam int STD_PINS   = STD_PORTS * PORT_W;
   localparam int HV_PINS    = HV_PORTS * PORT_W;

   logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
   logic [SEL_W-1:0]    sel = '0;
   logic [PORT_W-1:0]   wr_data = '0, rd_data;
   logic [STD_PINS-1:0] std_pad_in = '0, std_pmos_en, std_nmos_en, std_pu_en;
   logic [HV_PINS-1:0]  hv_pad_in = '0, hv_pmos_en, hv_nmos_en;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [PORT_W-1:0] m_sd  [STD_PORTS];
   logic [PORT_W-1:0] m_dir [STD_PORTS];
   logic [PORT_W-1:0] m_hv  [HV_PORTS];
   logic              m_pu;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_pin_ctrl #(.PORT_W(PORT_W), .STD_PORTS(STD_PORTS), .HV_PORTS(HV_PORTS),
                   .IDX_W(IDX_W)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wr_data(wr_data),
      .rd_data(rd_data), .std_pad_in(std_pad_in), .hv_pad_in(hv_pad_in),
      .std_pmos_en(std_pmos_en), .std_nmos_en(std_nmos_en), .std_pu_en(std_pu_en),
      .hv_pmos_en(hv_pmos_en), .hv_nmos_en(hv_nmos_en)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [STD_PINS-1:0] e_pmos();
      logic [STD_PINS-1:0] v;
      for (int p = 0; p < STD_PORTS; p++) v[p*PORT_W +: PORT_W] = m_dir[p] & m_sd[p];
      return v;
   endfunction
   function automatic logic [STD_PINS-1:0] e_nmos();
      logic [STD_PINS-1:0] v;
      for (int p = 0; p < STD_PORTS; p++) v[p*PORT_W +: PORT_W] = m_dir[p] & ~m_sd[p];
      return v;
   endfunction
   function automatic logic [STD_PINS-1:0] e_pu();
      logic [STD_PINS-1:0] v;
      for (int p = 0; p < STD_PORTS; p++) v[p*PORT_W +: PORT_W] = m_pu ? m_sd[p] : '0;
      return v;
   endfunction
   function automatic logic [HV_PINS-1:0] e_hv();
      logic [HV_PINS-1:0] v;
      for (int p = 0; p < HV_PORTS; p++) v[p*PORT_W +: PORT_W] = m_hv[p];
      return v;
   endfunction

   task automatic check_outs(input string tag);
      chk({tag, " R2 pmos"}, 64'(std_pmos_en), 64'(e_pmos()));
      chk({tag, " R3 nmos"}, 64'(std_nmos_en), 64'(e_nmos()));
      chk({tag, " R4 pullup"}, 64'(std_pu_en), 64'(e_pu()));
      chk({tag, " R6 hv pmos"}, 64'(hv_pmos_en), 64'(e_hv()));
      chk({tag, " R6 hv nmos"}, 64'(hv_nmos_en), 64'(0));
   endtask

   // drive at negedge, capture at posedge, return at next negedge
   task automatic wr(input logic [1:0] k, input logic [IDX_W-1:0] i, input logic [PORT_W-1:0] d);
      wr_en = 1'b1; sel = {k, i}; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      case (k)
         2'd0: if (i < STD_PORTS) m_sd[i]  = d;
         2'd1: if (i < STD_PORTS) m_dir[i] = d;
         2'd2: if (i < HV_PORTS)  m_hv[i]  = d;
         default: m_pu = d[0];
      endcase
   endtask

   task automatic rd_chk(input string req, input logic [1:0] k, input logic [IDX_W-1:0] i,
                         input logic [PORT_W-1:0] exp);
      sel = {k, i}; #1;
      chk(req, 64'(rd_data), 64'(exp));
   endtask

   initial begin
      for (int p = 0; p < STD_PORTS; p++) begin m_sd[p] = '0; m_dir[p] = '0; end
      for (int p = 0; p < HV_PORTS; p++) m_hv[p] = '0;
      m_pu = 1'b0;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      check_outs("reset R1");
      rd_chk("R1 misc reads 0", 2'd3, '0, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: pull-up on an input pin
      wr(2'd3, '0, 4'h1);
      wr(2'd0, 2'd1, 4'b1010);
      check_outs("pu input R4");
      chk("R4 pu with dir 0", 64'(std_pu_en[7:4]), 64'(4'b1010));
      wr(2'd1, 2'd1, 4'b1111);
      check_outs("pu output R2");
      // R8: invalid index ignored
      wr(2'd0, 2'd3, 4'hF);
      wr(2'd1, 2'd3, 4'hF);
      check_outs("invalid idx R8");
      rd_chk("R9 invalid idx read", 2'd1, 2'd3, '0);
      // R5
      wr(2'd3, '0, 4'hE);
      check_outs("pu off R5");
      chk("R5 all pu off", 64'(std_pu_en), 64'(0));
      rd_chk("R9 misc bit0", 2'd3, '0, 4'h0);
      // R8 write timing: not visible before the edge
      wr_en = 1'b1; sel = {2'd2, 2'd2}; wr_data = 4'h9; #1;
      chk("R8 no effect before edge", 64'(hv_pmos_en[11:8]), 64'(0));
      @(negedge clk); wr_en = 1'b0; m_hv[2] = 4'h9;
      chk("R8 after edge", 64'(hv_pmos_en[11:8]), 64'(4'h9));

      // R7 synchronizer latency, std and hv
      sel = {2'd0, 2'd2};
      std_pad_in[11:8] = 4'h6;
      @(negedge clk); #1;
      chk("R7 std pad not after one edge", 64'(rd_data), 64'(0));
      @(negedge clk); #1;
      chk("R7 std pad after two edges", 64'(rd_data), 64'(4'h6));
      sel = {2'd2, 2'd3};
      hv_pad_in[15:12] = 4'hB;
      @(negedge clk); #1;
      chk("R7 hv pad not after one edge", 64'(rd_data), 64'(0));
      @(negedge clk); #1;
      chk("R7 hv pad after two edges", 64'(rd_data), 64'(4'hB));
      @(negedge clk);

      // random
      for (int n = 0; n < 400; n++) begin
         logic [1:0] k;
         logic [IDX_W-1:0] i;
         k = 2'($urandom); i = IDX_W'($urandom);
         if (n % 25 == 0) begin
            std_pad_in = STD_PINS'($urandom);
            hv_pad_in  = HV_PINS'($urandom);
            repeat (3) @(negedge clk);
         end
         wr(k, i, PORT_W'($urandom));
         check_outs("random R8");
         begin
            logic [1:0] rk;
            logic [IDX_W-1:0] ri;
            logic [PORT_W-1:0] ex;
            rk = 2'($urandom); ri = IDX_W'($urandom);
            ex = '0;
            case (rk)
               2'd0: if (ri < STD_PORTS) ex = std_pad_in[ri*PORT_W +: PORT_W];
               2'd1: if (ri < STD_PORTS) ex = m_dir[ri];
               2'd2: if (ri < HV_PORTS)  ex = hv_pad_in[ri*PORT_W +: PORT_W];
               default: ex = {{(PORT_W-1){1'b0}}, m_pu};
            endcase
            rd_chk("random read R9 R7", rk, ri, ex);
         end
         @(negedge clk);
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule